// File: doc/BRIEF.md
# Event Counter Unit with Split Registers

This block counts hardware events for performance analysis. It has one free-running cycle counter and four programmable 32-bit event counters. Each event counter picks one line of an event pulse vector through an 8-bit selector. A counter counts in every clock cycle in which its line is high and the unit is enabled. The cycle counter counts clock cycles. It can also count once every 64 cycles, which stretches the time before it wraps.

Software controls the unit through a synchronous register port. Control, overflow flags, interrupt enables and event selection are each held in their own register. The overflow flags, the interrupt enables and the counter order all use the same bit order: bit 0 is the cycle counter and bit n+1 is event counter n. When a counter wraps, its flag is set. The level interrupt output is high while any flag is set whose interrupt enable is also set.

Software handles an overflow in three steps. It clears the enable bit so that counting freezes. It then reads the flags and clears them by writing ones. Finally it enables the unit again.

Top module: `evcnt_unit`

## Requirements
- R1: After reset the outputs and registers read as follows. Control reads 0xA5000000, with the identification constant in bits 31:24. Flags, interrupt enables and all counters read 0. Event select reads 0xFFFFFFFF. `rd_data` is 0 and `irq` is low.
- R2: Control (address 0) stores enable in bit 0 and divide-by-64 in bit 3. Bits 23:4 always read 0, and bits 31:24 always read the identification constant, whatever was written to them.
- R3: While the enable bit is 0, no counter changes, except through a direct write or a reset bit.
- R4: With enable set and divide-by-64 clear, the cycle counter (address 4) grows by one on every clock edge. Counting starts at the edge after the one that wrote enable and includes the edge that writes it clear.
- R5: With divide-by-64 set, the cycle counter grows by one once every 64 enabled clock edges.
- R6: Event counter n (address 5+n) grows by one on each enabled edge where its selected event line is high. A selector of 0xFF, or one beyond the event vector, never counts.
- R7: Event select (address 3) holds the selector of counter n in bits 8n+7:8n. Each counter follows only its own field.
- R8: A counter that steps from all ones to zero sets its flag in the flag register (address 1): bit 0 for the cycle counter, bit n+1 for event counter n.
- R9: Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged. If a clear and a new overflow hit the same flag in one cycle, the flag stays set.
- R10: The interrupt enable register (address 2) uses the flag bit order. `irq` is high exactly when some flag and its enable bit are both 1.
- R11: Writing control with bit 1 set zeroes all event counters. Writing it with bit 2 set zeroes the cycle counter and the prescaler. Both bits read back as 0.
- R12: A write to a counter address loads the value. If the counter would also count in that cycle, the written value wins and no overflow is flagged.
- R13: `rd_data` takes the addressed register on the clock edge where `rd_en` is high. It holds its value while `rd_en` is low. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NEV | Event pulse lines |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The bench drives counters to one step below wrap, so overflow is checked on the exact edge where it happens. A design that compared against the wrong value, or flagged on the wrong step, would show a flag on a counter that has not wrapped. A clear that lands in the same cycle as a new wrap is checked directly: a design that gave the clear priority would lose that overflow. Counting windows are sized to the edge, so an enable that takes effect one cycle early or late shows up as an off-by-one count. The prescaler is stopped at 63 enabled edges and then run to 64, which catches a divide-by-63 or a divide-by-65. A counter write is placed in a counting cycle to show that the written value wins. Writes to the reserved control bits, and selectors set to unused, are checked for having no effect.

// File: rtl/evcnt_unit.sv
module evcnt_unit #(
  parameter int NEV = 8,
  parameter int NEC = 4,
  parameter int CW = 32,
  parameter int SELW = 8,
  parameter int PRE_LOG = 6,
  parameter int AW = 4,
  parameter logic [7:0] ID = 8'hA5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] evt_i,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [31:0]    wr_data,
  output logic [31:0]    rd_data,
  output logic           irq
);
  localparam int NC = NEC + 1;
  localparam int SI = (NEV > 1) ? $clog2(NEV) : 1;
  localparam int CNT_BASE = 4;
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_FLAG = AW'(1);
  localparam logic [AW-1:0] A_IEN  = AW'(2);
  localparam logic [AW-1:0] A_SEL  = AW'(3);

  logic                      en_q, div_q;
  logic [PRE_LOG-1:0]        pre_q;
  logic [NC-1:0]             flag_q, ien_q;
  logic [NEC-1:0][SELW-1:0]  sel_q;
  logic [NC-1:0][CW-1:0]     cnt_q;
  logic [31:0]               rd_q, rd_mux;

  logic wr_ctrl, rst_ev, rst_cyc, tick;
  logic [NC-1:0] inc, zap, wr_cnt, ovf, clr;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign rst_ev  = wr_ctrl & wr_data[1];
  assign rst_cyc = wr_ctrl & wr_data[2];
  assign tick    = ~div_q | (&pre_q);
  assign clr     = (wr_en && (addr == A_FLAG)) ? wr_data[NC-1:0] : '0;

  assign inc[0] = en_q & tick;
  assign zap[0] = rst_cyc;

  for (genvar e = 0; e < NEC; e++) begin : g_ev
    logic [SELW-1:0] s;
    assign s          = sel_q[e];
    assign inc[e+1]   = en_q && (s != '1) && (s < SELW'(NEV)) && evt_i[s[SI-1:0]];
    assign zap[e+1]   = rst_ev;
  end

  for (genvar k = 0; k < NC; k++) begin : g_cnt
    assign wr_cnt[k] = wr_en && (addr == AW'(CNT_BASE + k));
    assign ovf[k]    = inc[k] & (&cnt_q[k]) & ~wr_cnt[k] & ~zap[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      for (int k = 0; k < NC; k++) begin
        if (wr_cnt[k])    cnt_q[k] <= wr_data[CW-1:0];
        else if (zap[k])  cnt_q[k] <= '0;
        else if (inc[k])  cnt_q[k] <= cnt_q[k] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      div_q  <= 1'b0;
      pre_q  <= '0;
      flag_q <= '0;
      ien_q  <= '0;
      sel_q  <= '1;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wr_data[0];
        div_q <= wr_data[3];
      end
      if (rst_cyc)             pre_q <= '0;
      else if (en_q && div_q)  pre_q <= pre_q + 1'b1;
      flag_q <= (flag_q & ~clr) | ovf;
      if (wr_en && addr == A_IEN) ien_q <= wr_data[NC-1:0];
      if (wr_en && addr == A_SEL) sel_q <= wr_data[NEC*SELW-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL:  rd_mux = {ID, 20'd0, div_q, 2'b00, en_q};
      A_FLAG:  rd_mux[NC-1:0] = flag_q;
      A_IEN:   rd_mux[NC-1:0] = ien_q;
      A_SEL:   rd_mux[NEC*SELW-1:0] = sel_q;
      default: ;
    endcase
    for (int k = 0; k < NC; k++)
      if (addr == AW'(CNT_BASE + k)) rd_mux[CW-1:0] = cnt_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_en)  rd_q <= rd_mux;
  end

  assign rd_data = rd_q;
  assign irq     = |(flag_q & ien_q);
endmodule

// File: rtl/evcnt_unit_chk.sv
module evcnt_unit_chk #(
  parameter int NEC = 4,
  parameter int CW = 32,
  parameter int SELW = 8,
  parameter int AW = 4,
  parameter logic [7:0] ID = 8'hA5,
  localparam int NC = NEC + 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [AW-1:0]            addr,
  input logic [NC-1:0]            wr_lo,
  input logic [31:0]              rd_data,
  input logic                     irq,
  input logic                     en_q,
  input logic [NC-1:0]            flag_q,
  input logic [NC-1:0]            ien_q,
  input logic [NEC-1:0][SELW-1:0] sel_q,
  input logic [NC-1:0][CW-1:0]    cnt_q
);
  p_ctrl_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == AW'(0)) |=> (rd_data[23:4] == 20'd0 && rd_data[31:24] == ID));

  p_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_en) |=> $stable(cnt_q));

  p_no_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0 || flag_q == '0) |-> !irq);

  p_rd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  for (genvar k = 0; k < NC; k++) begin : g_k
    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[k]) |-> (cnt_q[k] == '0));
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'(1) && wr_lo[k] && !en_q) |=> !flag_q[k]);
  end

  for (genvar e = 0; e < NEC; e++) begin : g_e
    p_unused_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[e] == '1 && !wr_en) |=> $stable(cnt_q[e+1]));
  end
endmodule

bind evcnt_unit evcnt_unit_chk #(.NEC(NEC), .CW(CW), .SELW(SELW), .AW(AW), .ID(ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_lo(wr_data[NC-1:0]), .rd_data(rd_data), .irq(irq), .en_q(en_q),
  .flag_q(flag_q), .ien_q(ien_q), .sel_q(sel_q), .cnt_q(cnt_q)
);

// File: tb/evcnt_unit_bench.sv
`timescale 1ns/1ps
module evcnt_unit_bench;
  localparam int NEV = 8;
  localparam int NV = 64;
  // op[75:72] 0 write, 1 read+compare, 2 idle data cycles, 3 drive events, 4 compare irq
  // req[71:68], addr[67:64], data[63:32], expected[31:0]
  localparam logic [75:0] TBL [NV] = '{
    {4'd1, 4'd1,  4'h0, 32'h0,        32'hA5000000}, // R1 control after reset
    {4'd1, 4'd1,  4'h1, 32'h0,        32'h0},        // R1 flags
    {4'd1, 4'd1,  4'h3, 32'h0,        32'hFFFFFFFF}, // R1 selectors all unused
    {4'd1, 4'd1,  4'h4, 32'h0,        32'h0},        // R1 cycle counter
    {4'd4, 4'd1,  4'h0, 32'h0,        32'h0},        // R1 irq low
    {4'd0, 4'd2,  4'h0, 32'hFFFFFFF8, 32'h0},        // R2 reserved bits written
    {4'd1, 4'd2,  4'h0, 32'h0,        32'hA5000008}, // R2
    {4'd0, 4'd2,  4'h0, 32'h0,        32'h0},
    {4'd0, 4'd7,  4'h3, 32'hFF020100, 32'h0},        // R7 c0<-0 c1<-1 c2<-2 c3 off
    {4'd1, 4'd7,  4'h3, 32'h0,        32'hFF020100}, // R7
    {4'd3, 4'd3,  4'h0, 32'h7,        32'h0},
    {4'd2, 4'd3,  4'h0, 32'd5,        32'h0},
    {4'd1, 4'd3,  4'h5, 32'h0,        32'h0},        // R3 disabled, no count
    {4'd1, 4'd3,  4'h4, 32'h0,        32'h0},        // R3
    {4'd0, 4'd4,  4'h0, 32'h1,        32'h0},
    {4'd2, 4'd4,  4'h0, 32'd9,        32'h0},
    {4'd0, 4'd4,  4'h0, 32'h0,        32'h0},
    {4'd1, 4'd4,  4'h4, 32'h0,        32'd10},       // R4 ten enabled edges
    {4'd1, 4'd6,  4'h5, 32'h0,        32'd10},       // R6
    {4'd1, 4'd6,  4'h6, 32'h0,        32'd10},       // R6
    {4'd1, 4'd6,  4'h7, 32'h0,        32'd10},       // R6
    {4'd1, 4'd6,  4'h8, 32'h0,        32'd0},        // R6 selector 0xFF
    {4'd3, 4'd7,  4'h0, 32'h2,        32'h0},
    {4'd0, 4'd7,  4'h0, 32'h1,        32'h0},
    {4'd2, 4'd7,  4'h0, 32'd5,        32'h0},
    {4'd0, 4'd7,  4'h0, 32'h0,        32'h0},
    {4'd1, 4'd7,  4'h4, 32'h0,        32'd16},       // R7
    {4'd1, 4'd7,  4'h5, 32'h0,        32'd10},       // R7 line 0 idle
    {4'd1, 4'd7,  4'h6, 32'h0,        32'd16},       // R7 line 1 active
    {4'd1, 4'd7,  4'h7, 32'h0,        32'd10},       // R7
    {4'd0, 4'd11, 4'h0, 32'h2,        32'h0},        // R11 event reset
    {4'd1, 4'd11, 4'h5, 32'h0,        32'h0},
    {4'd1, 4'd11, 4'h6, 32'h0,        32'h0},
    {4'd1, 4'd11, 4'h4, 32'h0,        32'd16},       // R11 cycle untouched
    {4'd0, 4'd11, 4'h0, 32'h4,        32'h0},        // R11 cycle reset
    {4'd1, 4'd11, 4'h4, 32'h0,        32'h0},
    {4'd1, 4'd11, 4'h0, 32'h0,        32'hA5000000}, // R11 reset bits read 0
    {4'd0, 4'd12, 4'h5, 32'hFFFFFFFE, 32'h0},
    {4'd1, 4'd12, 4'h5, 32'h0,        32'hFFFFFFFE}, // R12
    {4'd3, 4'd8,  4'h0, 32'h1,        32'h0},
    {4'd0, 4'd8,  4'h0, 32'h1,        32'h0},
    {4'd2, 4'd8,  4'h0, 32'd1,        32'h0},
    {4'd0, 4'd8,  4'h0, 32'h0,        32'h0},
    {4'd1, 4'd8,  4'h5, 32'h0,        32'h0},        // R8 wrapped
    {4'd1, 4'd8,  4'h1, 32'h0,        32'h2},        // R8 flag bit 1
    {4'd1, 4'd8,  4'h4, 32'h0,        32'd2},
    {4'd4, 4'd10, 4'h0, 32'h0,        32'h0},        // R10 not enabled
    {4'd0, 4'd10, 4'h2, 32'h2,        32'h0},
    {4'd4, 4'd10, 4'h0, 32'h0,        32'h1},        // R10
    {4'd0, 4'd10, 4'h2, 32'h1,        32'h0},
    {4'd4, 4'd10, 4'h0, 32'h0,        32'h0},        // R10 other bit
    {4'd1, 4'd10, 4'h2, 32'h0,        32'h1},
    {4'd0, 4'd10, 4'h2, 32'h3,        32'h0},
    {4'd0, 4'd9,  4'h1, 32'h0,        32'h0},
    {4'd1, 4'd9,  4'h1, 32'h0,        32'h2},        // R9 zero write no effect
    {4'd0, 4'd9,  4'h1, 32'h2,        32'h0},
    {4'd1, 4'd9,  4'h1, 32'h0,        32'h0},        // R9 cleared
    {4'd4, 4'd9,  4'h0, 32'h0,        32'h0},
    {4'd3, 4'd8,  4'h0, 32'h0,        32'h0},
    {4'd0, 4'd8,  4'h4, 32'hFFFFFFFF, 32'h0},
    {4'd0, 4'd8,  4'h0, 32'h1,        32'h0},
    {4'd0, 4'd8,  4'h0, 32'h0,        32'h0},
    {4'd1, 4'd8,  4'h1, 32'h0,        32'h1},        // R8 cycle counter flag
    {4'd4, 4'd10, 4'h0, 32'h0,        32'h1}         // R10
  };

  logic clk = 1'b0;
  logic rst_n, wr_en, rd_en, irq;
  logic [NEV-1:0] evt;
  logic [3:0] addr;
  logic [31:0] wr_data, rd_data, v;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  evcnt_unit #(.NEV(NEV)) u_evcnt_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  task automatic chk(input int r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] q);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    q = rd_data;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0; evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(1, rd_data, 32'h0);  // R1
    chk(1, {31'd0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [75:0] t;
      t = TBL[i];
      case (t[75:72])
        4'd0: wr(t[67:64], t[63:32]);
        4'd1: begin rd(t[67:64], v); chk(int'(t[71:68]), v, t[31:0]); end
        4'd2: repeat (t[63:32]) @(negedge clk);
        4'd3: evt = t[32 +: NEV];
        default: chk(int'(t[71:68]), {31'd0, irq}, t[31:0]);
      endcase
    end

    // R9: clear and new wrap of the cycle counter on the same edge
    wr(4'h4, 32'hFFFFFFFE);
    wr(4'h0, 32'h1);
    @(negedge clk);
    wr(4'h1, 32'h1);
    wr(4'h0, 32'h0);
    rd(4'h1, v); chk(9, v, 32'h1);
    rd(4'h4, v); chk(9, v, 32'h1);
    wr(4'h1, 32'h1F);
    rd(4'h1, v); chk(9, v, 32'h0);
    chk(10, {31'd0, irq}, 32'h0);

    // R5: 63 enabled edges give no step, the 64th does
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h9);
    repeat (62) @(negedge clk);
    wr(4'h0, 32'h0);
    rd(4'h4, v); chk(5, v, 32'h0);
    wr(4'h0, 32'h9);
    wr(4'h0, 32'h0);
    rd(4'h4, v); chk(5, v, 32'h1);

    // R12: direct write beats a count on the same edge
    evt = 8'h2;
    wr(4'h0, 32'h1);
    wr(4'h6, 32'd100);
    wr(4'h0, 32'h0);
    evt = '0;
    rd(4'h6, v); chk(12, v, 32'd101);

    // R13: read data holds while rd_en is low
    addr = 4'h0;
    repeat (2) @(negedge clk);
    chk(13, rd_data, 32'd101);
    rd(4'hC, v); chk(13, v, 32'h0);

    // R1: reset in mid-run
    wr(4'h2, 32'h1F);
    wr(4'h3, 32'h0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    chk(1, rd_data, 32'h0);
    rd(4'h3, v); chk(1, v, 32'hFFFFFFFF);
    rd(4'h2, v); chk(1, v, 32'h0);
    rd(4'h6, v); chk(1, v, 32'h0);
    chk(1, {31'd0, irq}, 32'h0);

    finish_run();
  end
endmodule